// File: doc/BRIEF.md
# Almost-Full Aware Round Robin Request Scheduler

This block paces reads out of a multi-channel source. It issues one request per clock cycle over a memory-mapped write port. Each request is a write whose address selects a channel and whose data asks for a single unit. The channel slot moves through the channels in ascending order, one slot per clock, and wraps from the last channel back to channel 0.

A per-channel almost-full flag is kept inside the block. A status stream updates the flags: each beat carries a valid strobe, a channel index and a one-bit flag. When the slot lands on a channel whose flag is set, that cycle passes with no write, and the slot still moves on. The target's waitrequest is the only backpressure. While it is high, the presented write is frozen and the slot does not move.

The control is a two-state machine. In `SLOT_SCAN` the current slot is judged from its stored flag. A clear channel is written. A flagged channel is an idle cycle and the slot steps. The transition `SCAN_TO_HOLD` is taken when a clear slot's write meets waitrequest. In `SLOT_HOLD` the write stays asserted whatever the flag of that channel does. The transition `HOLD_TO_SCAN` is taken on the cycle waitrequest falls, and the slot steps at the same edge. Both states loop on themselves otherwise: `SCAN_STAY` and `HOLD_STAY`.

Top module: `rr_req_sched`

## Requirements
- R1: Whenever `req_wr` is high, `req_wdata` equals 1.
- R2: A write for channel n carries address 4×n: bits [1:0] are zero and bits [ADDR_W-1:2] hold n (channel 3 gives address 12).
- R3: The slot advances by one channel in ascending order on each clock edge where it is not stalled, and it wraps from NUM_CHANNELS−1 to 0.
- R4: A slot whose channel has its stored almost-full flag at 1 drives `req_wr` low for that cycle, and the slot moves to the next channel on the following edge.
- R5: While `req_wr` and `req_wait` are both high at a clock edge, the next cycle keeps `req_wr` high with the same `req_addr` and `req_wdata`, and the slot does not advance.
- R6: `rst_n` low clears all almost-full flags at once, without waiting for a clock, returns the slot to channel 0, and leaves the machine in `SLOT_SCAN`. Channel 0 is presented as a write while reset is held.
- R7: A status beat (`st_valid`=1) sets the flag of channel `st_chan` to `st_full` (1 = almost full, 0 = clear) at the clock edge where it arrives. It governs that channel's next slot. A beat aimed at the channel of the current slot does not change the decision for the current slot.
- R8: Once a write has been stalled by `req_wait`, it stays asserted until accepted, even if its channel is marked almost full during the stall.
- R9: A beat with `st_valid`=0 changes no flag, whatever `st_chan` and `st_full` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_addr | output | ADDR_W (clog2(NUM_CHANNELS)+2) | Request write address, 4× the channel index |
| req_wr | output | 1 | Request write strobe |
| req_wdata | output | DATA_W | Request write data, constant 1 |
| req_wait | input | 1 | Target backpressure; holds the current write |
| st_valid | input | 1 | Status beat valid |
| st_chan | input | CH_W (clog2(NUM_CHANNELS)) | Channel addressed by the status beat |
| st_full | input | 1 | 1 marks the channel almost full, 0 clears it |

## Verification
The hardest case to reach from the ports is a stalled write whose own channel becomes almost full while waitrequest is still high. To reach it, the stimulus first lets the slot land on a clear channel with waitrequest raised. It then sends a status beat for that very channel in the middle of the stall. Finally it drops waitrequest a cycle later and checks that the write persisted and that the flag only affects the channel's next slot. The same table also sends status beats aimed at the slot being served, in both directions, to pin down which flag value decides a slot. A directed test then pulls reset low in mid-cycle during a stall and checks that flags set earlier no longer block their channels.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;

    typedef enum logic [0:0] {
        SLOT_SCAN = 1'b0,
        SLOT_HOLD = 1'b1
    } slot_state_e;

endpackage

// File: rtl/rr_flag_table.sv
module rr_flag_table #(
    parameter int NUM_CHANNELS = 8,
    parameter int CH_W         = $clog2(NUM_CHANNELS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_valid,
    input  logic [CH_W-1:0] upd_chan,
    input  logic            upd_flag,
    input  logic [CH_W-1:0] rd_chan,
    output logic            rd_flag
);

    logic [NUM_CHANNELS-1:0] flags;

    generate
        for (genvar g = 0; g < NUM_CHANNELS; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[g] <= 1'b0;
                end else if (upd_valid && (upd_chan == CH_W'(g))) begin
                    flags[g] <= upd_flag;
                end
            end
        end
    endgenerate

    // the stored value before this edge decides the current slot
    assign rd_flag = flags[rd_chan];

    // R7
    flag_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (int'(upd_chan) < NUM_CHANNELS)) |=> (flags[$past(upd_chan)] == $past(upd_flag)));

    // R9
    flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(flags));

endmodule

// File: rtl/rr_slot_ptr.sv
module rr_slot_ptr #(
    parameter int NUM_CHANNELS = 8,
    parameter int CH_W         = $clog2(NUM_CHANNELS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [CH_W-1:0] cur_chan
);

    localparam logic [CH_W-1:0] LAST_CHAN = CH_W'(NUM_CHANNELS - 1);

    logic [CH_W-1:0] nxt_chan;

    always_comb begin
        if (cur_chan == LAST_CHAN) begin
            nxt_chan = '0;
        end else begin
            nxt_chan = cur_chan + CH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_chan <= '0;
        end else if (step) begin
            cur_chan <= nxt_chan;
        end
    end

    // R3
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cur_chan == (($past(cur_chan) == LAST_CHAN) ? '0 : $past(cur_chan) + CH_W'(1))));

    // R5
    slot_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cur_chan));

endmodule

// File: rtl/rr_req_fsm.sv
module rr_req_fsm
    import rr_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_blocked,
    input  logic req_wait,
    output logic req_wr,
    output logic step
);

    slot_state_e state;
    slot_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SLOT_SCAN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        req_wr    = 1'b0;
        step      = 1'b0;
        state_nxt = state;
        unique case (state)
            SLOT_SCAN: begin
                if (slot_blocked) begin
                    step = 1'b1;
                end else begin
                    req_wr = 1'b1;
                    if (req_wait) begin
                        state_nxt = SLOT_HOLD;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            SLOT_HOLD: begin
                req_wr = 1'b1;
                if (!req_wait) begin
                    step      = 1'b1;
                    state_nxt = SLOT_SCAN;
                end
            end
            default: begin
                state_nxt = SLOT_SCAN;
            end
        endcase
    end

    // R4
    blocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_SCAN && slot_blocked) |-> (!req_wr && step));

    // R8
    hold_keeps_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_HOLD) |-> req_wr);

    // R5
    stall_enters_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_wait) |=> (state == SLOT_HOLD));

endmodule

// File: rtl/rr_req_sched.sv
module rr_req_sched #(
    parameter int NUM_CHANNELS = 8,
    parameter int DATA_W       = 32,
    parameter int CH_W         = $clog2(NUM_CHANNELS),
    parameter int ADDR_W       = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_wr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_wait,
    input  logic              st_valid,
    input  logic [CH_W-1:0]   st_chan,
    input  logic              st_full
);

    logic [CH_W-1:0] cur_chan;
    logic            slot_blocked;
    logic            step;

    rr_flag_table #(
        .NUM_CHANNELS (NUM_CHANNELS),
        .CH_W         (CH_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (st_valid),
        .upd_chan  (st_chan),
        .upd_flag  (st_full),
        .rd_chan   (cur_chan),
        .rd_flag   (slot_blocked)
    );

    rr_slot_ptr #(
        .NUM_CHANNELS (NUM_CHANNELS),
        .CH_W         (CH_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .cur_chan (cur_chan)
    );

    rr_req_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_blocked (slot_blocked),
        .req_wait     (req_wait),
        .req_wr       (req_wr),
        .step         (step)
    );

    // word address: channel index shifted past the byte lanes
    assign req_addr  = {cur_chan, 2'b00};
    assign req_wdata = DATA_W'(1);

    // R5
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_wait) |=> (req_wr && $stable(req_addr) && $stable(req_wdata)));

    // R1
    unit_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |-> (req_wdata == DATA_W'(1)));

endmodule

// File: tb/rr_req_sched_bench.sv
module rr_req_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 8;
    localparam int DW     = 32;
    localparam int CW     = 3;
    localparam int AW     = 5;
    localparam int NVEC   = 20;

    // {req_id[15:12], wait[11], st_valid[10], st_chan[9:7], st_full[6], exp_wr[5], exp_addr[4:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {4'd3, 1'b0, 1'b1, 3'd2, 1'b1, 1'b1, 5'd0 },  // R3 ch0 write, mark ch2 full
        {4'd2, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd4 },  // R2 ch1 address 4
        {4'd4, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 5'd0 },  // R4 ch2 idle
        {4'd2, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 5'd12},  // R2 ch3 address 12, stall
        {4'd5, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 5'd12},  // R5 held, mark ch3 full mid-stall
        {4'd8, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd12},  // R8 still writing ch3, accepted
        {4'd3, 1'b0, 1'b1, 3'd5, 1'b1, 1'b1, 5'd16},  // R3 ch4, mark ch5 full
        {4'd7, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0, 5'd0 },  // R7 ch5 idle though cleared now
        {4'd7, 1'b0, 1'b1, 3'd6, 1'b1, 1'b1, 5'd24},  // R7 ch6 writes though marked now
        {4'd3, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 5'd28},  // R3 ch7, invalid beat for ch0
        {4'd9, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1, 5'd0 },  // R9 wrap to ch0, still clear; clear ch2
        {4'd3, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd4 },  // R3 ch1
        {4'd7, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd8 },  // R7 ch2 cleared
        {4'd4, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 5'd0 },  // R4 ch3 idle
        {4'd3, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd16},  // R3 ch4
        {4'd7, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd20},  // R7 ch5 cleared
        {4'd4, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 5'd0 },  // R4 ch6 idle
        {4'd3, 1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 5'd28},  // R3 ch7, stall
        {4'd5, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd28},  // R5 ch7 held, accepted
        {4'd3, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 5'd0 }   // R3 wrap to ch0
    };

    logic          clk;
    logic          rst_n;
    logic [AW-1:0] req_addr;
    logic          req_wr;
    logic [DW-1:0] req_wdata;
    logic          req_wait;
    logic          st_valid;
    logic [CW-1:0] st_chan;
    logic          st_full;

    int n_checks;
    int n_fails;
    bit finished;

    rr_req_sched #(
        .NUM_CHANNELS (NCH),
        .DATA_W       (DW)
    ) u_rr_req_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .req_wait  (req_wait),
        .st_valid  (st_valid),
        .st_chan   (st_chan),
        .st_full   (st_full)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // compares the slot outputs; address and data only matter when a write is expected
    task automatic check_slot(input string tag, input logic ewr, input logic [AW-1:0] eaddr);
        check(tag, "req_wr", longint'(req_wr), longint'(ewr));
        if (ewr) begin
            check(tag, "req_addr", longint'(req_addr), longint'(eaddr));
            check("R1", "req_wdata", longint'(req_wdata), 1);
        end
    endtask

    task automatic drive(input logic w, input logic v, input logic [CW-1:0] c, input logic f);
        req_wait = w;
        st_valid = v;
        st_chan  = c;
        st_full  = f;
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        finished = 1'b0;
        rst_n = 1'b0;
        drive(1'b0, 1'b0, '0, 1'b0);
        repeat (3) @(negedge clk);

        // R6 state held under reset: slot 0, no flag set
        check_slot("R6", 1'b1, 5'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v;
            string       tag;
            if (i > 0) @(negedge clk);
            v   = VEC[i];
            tag = $sformatf("R%0d", v[15:12]);
            check_slot(tag, v[5], v[4:0]);
            drive(v[11], v[10], v[9:7], v[6]);
        end

        // directed: flag, stall, then reset pulled low in mid-cycle
        @(negedge clk);
        check_slot("R3", 1'b1, 5'd4);
        drive(1'b0, 1'b1, 3'd2, 1'b1);
        @(negedge clk);
        check_slot("R4", 1'b0, 5'd0);      // ch2 marked this time
        drive(1'b0, 1'b0, '0, 1'b0);
        @(negedge clk);
        check_slot("R4", 1'b0, 5'd0);      // ch3 still marked from the table
        @(negedge clk);
        check_slot("R3", 1'b1, 5'd16);
        drive(1'b1, 1'b0, '0, 1'b0);
        @(negedge clk);
        check_slot("R5", 1'b1, 5'd16);
        #1 rst_n = 1'b0;
        #1 check_slot("R6", 1'b1, 5'd0);   // async: no clock edge yet
        @(negedge clk);
        check_slot("R6", 1'b1, 5'd0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, '0, 1'b0);
        @(negedge clk);
        check_slot("R6", 1'b1, 5'd4);
        @(negedge clk);
        check_slot("R6", 1'b1, 5'd8);      // ch2 flag gone
        @(negedge clk);
        check_slot("R6", 1'b1, 5'd12);     // ch3 flag gone

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule